// File: doc/BRIEF.md
# Memory-Mapped Cache Tag Store Port

This block holds the tag store of a two-way set-associative data cache and exposes it to software through a 32-bit memory-mapped window. A request carries an address and a data word. The address selects the window, a way, an entry and an association flag. The data word carries a tag, a dirty flag and a valid flag. Reads return the stored tag and flags of one way and entry. Direct writes load one way and entry with no comparison.

An associative write is the way software drops or cleans one line by its address. It ignores the way field and compares the supplied tag with the valid lines of both ways at the addressed entry. Only the way that hits takes the new flags. Suppose a dirty line loses its dirty flag or its valid flag. The block then asks an external line-flush unit for a write-back over a valid/ready channel. It applies the new flags only after that request is taken, and holds further bus requests until then.

The incoming tag is taken as a physical tag. A translation-miss input discards an associative write without any error. A translation-multiple-hit input aborts the write and pulses a fault output.

Top module: `tag_store_port`

## Requirements
- R1: A request whose address bits [31:24] differ from 0xF4 changes no stored state, and a read of such an address returns 0.
- R2: A write with address bit 3 at 0 stores data bits [31:10] as the tag, data bit 1 as the dirty flag and data bit 0 as the valid flag. They go into the way given by address bit 14 and the entry given by address bits [13:5]. Data bits [9:2] are ignored.
- R3: A read that is accepted on a clock edge raises rsp_valid for one cycle after that edge. rsp_rdata then holds the tag in bits [31:10], the dirty flag in bit 1, the valid flag in bit 0, and 0 in bits [9:2].
- R4: After reset every tag and flag is 0, req_ready is 1, and wb_valid, fault and rsp_valid are 0.
- R5: In a write with address bit 3 at 1, address bit 14 is ignored. A way whose valid flag is 1 and whose stored tag equals data bits [31:10] takes data bits [1:0] as its dirty and valid flags, and its tag is unchanged.
- R6: An associative write that matches no valid way changes nothing, raises no fault and requests no write-back.
- R7: An associative write made while xlat_miss is 1 changes nothing and raises no fault.
- R8: Suppose an associative hit finds the stored dirty flag at 1 and the write clears the dirty or the valid flag. Then wb_valid rises with wb_way, wb_entry and the stored tag. These stay stable until wb_ready is seen, req_ready stays 0 meanwhile, and the new flags are applied on the handshake.
- R9: An associative hit that clears neither flag of a dirty line, or that hits a clean line, updates at once with no write-back request.
- R10: An associative write made while xlat_multi is 1 changes nothing, and fault is 1 for exactly the cycle after the accepting edge.
- R11: When both ways hit in an associative write, only way 0 is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Window, way, entry and association flag |
| req_wdata | input | 32 | Tag and flags to write |
| xlat_miss | input | 1 | Translation miss for this request |
| xlat_multi | input | 1 | Translation multiple hit for this request |
| rsp_valid | output | 1 | Read data present |
| rsp_rdata | output | 32 | Read data |
| fault | output | 1 | Multiple-hit abort pulse |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back request taken |
| wb_way | output | 1 | Way of the line to flush |
| wb_entry | output | 9 | Entry of the line to flush |
| wb_tag | output | 22 | Stored tag of the line to flush |

## Verification
The assertions assume that xlat_miss and xlat_multi are only meaningful alongside an accepted request. They also assume that wb_ready may rise at any time, so a pending flush must hold its fields until then. They assume the requester honours req_ready. The stimulus therefore drives every request at a falling edge, only while req_ready is high, and holds it for one cycle. It raises the translation inputs only together with a request. It keeps wb_ready low until the held-request checks are done.

// File: rtl/tag_store_port.sv
module tag_store_port #(
  parameter int ENTRIES = 512,
  parameter int TAG_W = 22,
  parameter logic [7:0] WINDOW = 8'hF4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [31:0]                req_addr,
  input  logic [31:0]                req_wdata,
  input  logic                       xlat_miss,
  input  logic                       xlat_multi,
  output logic                       rsp_valid,
  output logic [31:0]                rsp_rdata,
  output logic                       fault,
  output logic                       wb_valid,
  input  logic                       wb_ready,
  output logic                       wb_way,
  output logic [$clog2(ENTRIES)-1:0] wb_entry,
  output logic [TAG_W-1:0]           wb_tag
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int WAY_BIT = 5 + IDX_W;
  localparam int PAD_W = 30 - TAG_W;

  logic [TAG_W-1:0] tag_q [2][ENTRIES];
  logic [ENTRIES-1:0] u_q [2];
  logic [ENTRIES-1:0] v_q [2];

  logic busy_q, p_way_q, p_u_q, p_v_q;
  logic [IDX_W-1:0] p_idx_q;
  logic [TAG_W-1:0] p_tag_q;

  logic acc, in_win, assoc, direct_wr, hit0, hit1, hway, any_hit, assoc_go, need_wb;
  logic way;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] wtag;
  logic wu, wv;

  assign req_ready = !busy_q;
  assign acc       = req_valid && req_ready;
  assign in_win    = req_addr[31:24] == WINDOW;
  assign assoc     = req_write && req_addr[3];
  assign direct_wr = acc && in_win && req_write && !req_addr[3];
  assign idx       = req_addr[5 +: IDX_W];
  assign way       = req_addr[WAY_BIT];
  assign wtag      = req_wdata[31 -: TAG_W];
  assign wu        = req_wdata[1];
  assign wv        = req_wdata[0];

  assign hit0    = v_q[0][idx] && (tag_q[0][idx] == wtag);
  assign hit1    = v_q[1][idx] && (tag_q[1][idx] == wtag);
  assign any_hit = hit0 || hit1;
  assign hway    = !hit0;
  assign assoc_go = acc && in_win && assoc && !xlat_miss && !xlat_multi && any_hit;
  assign need_wb  = assoc_go && u_q[hway][idx] && (!wu || !wv);

  logic unused_bits;
  assign unused_bits = ^{req_addr[23:WAY_BIT+1], req_addr[4], req_addr[2:0], req_wdata[31-TAG_W:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) begin
        u_q[w] <= '0;
        v_q[w] <= '0;
        for (int e = 0; e < ENTRIES; e++) tag_q[w][e] <= '0;
      end
    end else begin
      if (direct_wr) begin
        tag_q[way][idx] <= wtag;
        u_q[way][idx]   <= wu;
        v_q[way][idx]   <= wv;
      end
      if (assoc_go && !need_wb) begin
        u_q[hway][idx] <= wu;
        v_q[hway][idx] <= wv;
      end
      if (busy_q && wb_ready) begin
        u_q[p_way_q][p_idx_q] <= p_u_q;
        v_q[p_way_q][p_idx_q] <= p_v_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      p_way_q <= 1'b0;
      p_idx_q <= '0;
      p_tag_q <= '0;
      p_u_q   <= 1'b0;
      p_v_q   <= 1'b0;
    end else if (need_wb) begin
      busy_q  <= 1'b1;
      p_way_q <= hway;
      p_idx_q <= idx;
      p_tag_q <= tag_q[hway][idx];
      p_u_q   <= wu;
      p_v_q   <= wv;
    end else if (busy_q && wb_ready) begin
      busy_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      fault     <= 1'b0;
    end else begin
      rsp_valid <= acc && !req_write;
      if (acc && !req_write)
        rsp_rdata <= in_win ? {tag_q[way][idx], {PAD_W{1'b0}}, u_q[way][idx], v_q[way][idx]} : 32'd0;
      fault <= acc && in_win && assoc && xlat_multi;
    end
  end

  assign wb_valid = busy_q;
  assign wb_way   = p_way_q;
  assign wb_entry = p_idx_q;
  assign wb_tag   = p_tag_q;

  a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_way) && $stable(wb_entry) && $stable(wb_tag));
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !req_ready);
  a_r3_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);
  a_r10_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid && req_write && xlat_multi));
  a_r7_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && xlat_miss && !xlat_multi |=> !fault && !wb_valid);
endmodule

// File: tb/tag_store_port_tb.sv
module tag_store_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, xlat_miss = 0, xlat_multi = 0, wb_ready = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, fault, wb_valid, wb_way;
  logic [31:0] rsp_rdata;
  logic [8:0] wb_entry;
  logic [21:0] wb_tag;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string lbl_q[$];
  logic [21:0] m_tag [2][512];
  logic m_u [2][512];
  logic m_v [2][512];

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_store_port u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .xlat_miss(xlat_miss), .xlat_multi(xlat_multi), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .fault(fault), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_way(wb_way), .wb_entry(wb_entry), .wb_tag(wb_tag));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(bit a, bit w, int e, logic [7:0] win = 8'hF4);
    logic [8:0] ee = 9'(e);
    return {win, 9'd0, w, ee, 1'b0, a, 3'b000};
  endfunction

  function automatic logic [31:0] mk_data(logic [21:0] t, bit u, bit v);
    return {t, 8'hA5, u, v};
  endfunction

  task automatic bus(bit wr, logic [31:0] a, logic [31:0] d, bit miss = 0, bit multi = 0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    xlat_miss = miss; xlat_multi = multi;
    @(negedge clk);
    req_valid = 0; xlat_miss = 0; xlat_multi = 0;
  endtask

  task automatic wr_direct(bit w, int e, logic [21:0] t, bit u, bit v);
    bus(1, mk_addr(0, w, e), mk_data(t, u, v));
    m_tag[w][e] = t; m_u[w][e] = u; m_v[w][e] = v;
  endtask

  task automatic rd(bit w, int e, string req);
    exp_q.push_back({m_tag[w][e], 8'd0, m_u[w][e], m_v[w][e]});
    lbl_q.push_back(req);
    bus(0, mk_addr(0, w, e), 32'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R3 unexpected response", rsp_rdata, 32'hxxxxxxxx);
      else chk(lbl_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 512; e++) begin m_tag[w][e] = 0; m_u[w][e] = 0; m_v[w][e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 req_ready", req_ready, 1);
    chk("R4 wb_valid", wb_valid, 0);
    chk("R4 fault", fault, 0);
    chk("R4 rsp_valid", rsp_valid, 0);
    rd(0, 0, "R4 way0 entry0");
    rd(1, 511, "R4 way1 entry511");

    wr_direct(0, 5, 22'h2AAAAA, 1, 1);
    wr_direct(1, 5, 22'h155555, 0, 1);
    wr_direct(1, 511, 22'h3FFFFF, 1, 0);
    rd(0, 5, "R2 way0 entry5");
    rd(1, 5, "R2 way1 entry5");
    rd(1, 511, "R3 way1 entry511");

    bus(1, mk_addr(0, 0, 5, 8'hF5), mk_data(22'h000123, 0, 0));
    rd(0, 5, "R1 write outside window");
    exp_q.push_back(32'd0); lbl_q.push_back("R1 read outside window");
    bus(0, mk_addr(0, 0, 5, 8'hF5), 32'd0);

    bus(1, mk_addr(1, 0, 5), mk_data(22'h155555, 1, 1));
    m_u[1][5] = 1;
    chk("R9 no write-back on clean hit", wb_valid, 0);
    rd(1, 5, "R5 associative hit way1 with way bit 0");

    bus(1, mk_addr(1, 1, 5), mk_data(22'h0ABCDE, 0, 0));
    chk("R6 mismatch no write-back", wb_valid, 0);
    chk("R6 mismatch no fault", fault, 0);
    rd(0, 5, "R6 mismatch way0");
    rd(1, 5, "R6 mismatch way1");
    wr_direct(0, 7, 22'h0D0D0D, 0, 0);
    bus(1, mk_addr(1, 0, 7), mk_data(22'h0D0D0D, 1, 1));
    rd(0, 7, "R6 match on invalid way");

    bus(1, mk_addr(1, 0, 5), mk_data(22'h2AAAAA, 0, 0), 1, 0);
    chk("R7 miss no fault", fault, 0);
    chk("R7 miss no write-back", wb_valid, 0);
    rd(0, 5, "R7 miss discarded");

    bus(1, mk_addr(1, 1, 5), mk_data(22'h2AAAAA, 1, 1));
    chk("R9 dirty hit keeping flags", wb_valid, 0);
    rd(0, 5, "R9 dirty line unchanged");

    bus(1, mk_addr(1, 1, 5), mk_data(22'h2AAAAA, 1, 0));
    chk("R8 wb_valid", wb_valid, 1);
    chk("R8 wb_way", wb_way, 0);
    chk("R8 wb_entry", wb_entry, 5);
    chk("R8 wb_tag", wb_tag, 22'h2AAAAA);
    chk("R8 req_ready low", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R8 wb_valid held", wb_valid, 1);
    chk("R8 wb_tag held", wb_tag, 22'h2AAAAA);
    wb_ready = 1;
    @(negedge clk);
    wb_ready = 0;
    chk("R8 wb_valid drops", wb_valid, 0);
    chk("R8 req_ready back", req_ready, 1);
    m_v[0][5] = 0;
    rd(0, 5, "R8 commit after flush");

    bus(1, mk_addr(1, 0, 5), mk_data(22'h155555, 0, 1));
    chk("R8 clear dirty wb_valid", wb_valid, 1);
    chk("R8 clear dirty wb_way", wb_way, 1);
    wb_ready = 1;
    @(negedge clk);
    wb_ready = 0;
    m_u[1][5] = 0;
    rd(1, 5, "R8 clear dirty commit");

    bus(1, mk_addr(1, 0, 5), mk_data(22'h155555, 0, 0), 0, 1);
    chk("R10 fault pulse", fault, 1);
    @(negedge clk);
    chk("R10 fault single cycle", fault, 0);
    rd(1, 5, "R10 aborted write");

    wr_direct(0, 9, 22'h0EEEEE, 0, 1);
    wr_direct(1, 9, 22'h0EEEEE, 0, 1);
    bus(1, mk_addr(1, 1, 9), mk_data(22'h0EEEEE, 1, 0));
    m_u[0][9] = 1; m_v[0][9] = 0;
    rd(0, 9, "R11 way0 takes update");
    rd(1, 9, "R11 way1 untouched");

    repeat (3) @(negedge clk);
    chk("R3 all responses seen", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule